// File: doc/BRIEF.md
# Packed Video Pixel Unpacker

The unpacker sits between a video FIFO and the pixel pipeline of a display controller. It reads 64-bit words from the FIFO and sends out one pixel on a 24-bit bus for each pixel-clock enable. A mode input selects the pixel depth: 4, 8, 16 or 24 bits. A slot counter selects the slice of the current word that goes out. The same counter decides when the next word has to be fetched, so the read rate follows the depth. Deep pixels use up words quickly and shallow pixels use them slowly.

In dual-scan operation each word carries two screen halves side by side. Bits [31:0] belong to the upper half of the screen and bits [63:32] to the lower half. Pixels alternate between the two halves, so a single pixel stream carries both screen halves. When the FIFO cannot deliver a word in time, the block sets a sticky underflow flag and replays the word it already holds. Dropping the enable realigns the block to a word boundary for the next frame.

Top module: `pixel_unpacker`

## Requirements
- R1: While rst_ni is low, and after it is released with en_i low, pix_valid_o, fifo_rd_o and urun_o are all 0.
- R2: Depth codes on mode_i: 3'd1 is 4 bpp (16 pixels per word), 3'd2 is 8 bpp (8 per word), 3'd4 is 16 bpp (4 per word) and 3'd6 is 24 bpp (2 per word, bits [63:48] unused). Every other code behaves as 3'd2.
- R3: With dscan_i low, slot s of a word comes from bits [s*b +: b], where b is the depth in bits. Slot 0 is the least significant end. Pixels narrower than 24 bits are zero-extended in pix_o.
- R4: Each pix_ce_i cycle with a word held produces exactly one pixel. That pixel appears on pix_o with pix_valid_o high after the next clock edge. Cycles without pix_ce_i produce no pixel.
- R5: fifo_data_i is read show-ahead. fifo_rd_o pops one word and is never high while fifo_empty_i is high. After en_i rises, one word is fetched without waiting for pix_ce_i. After that, fifo_rd_o is high in the pix_ce_i cycle that takes the last slot of the current word, and the new word is used by the next pixel. One word is consumed for each full set of slots.
- R6: With dscan_i high, slot 2j comes from bits [j*b +: b] of the word and slot 2j+1 from bits [32 + j*b +: b]. At 24 bpp the two slots are bits [23:0] and [55:32].
- R7: When a word is needed while fifo_empty_i is high, urun_o is set. A word is needed when the last slot is taken, or when en_i is high with no word held and pix_ce_i is high. The word already held is then replayed from slot 0 and no read is issued.
- R8: urun_o stays set until urun_clr_i is high on a clock edge. A new underflow in the same cycle as a clear leaves urun_o set.
- R9: With en_i low, no pixel is produced and no word is read. The slot counter and the held word are dropped, so the next pixel after re-enabling is slot 0 of a freshly read word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Unpacker enable; low realigns to a word boundary |
| mode_i | input | 3 | Pixel depth code |
| dscan_i | input | 1 | Dual-scan interleave select |
| pix_ce_i | input | 1 | Pixel clock enable |
| fifo_data_i | input | 64 | FIFO head word (show-ahead) |
| fifo_empty_i | input | 1 | FIFO has no word |
| fifo_rd_o | output | 1 | Pop the FIFO head word |
| pix_o | output | 24 | Unpacked pixel |
| pix_valid_o | output | 1 | pix_o carries a new pixel |
| urun_clr_i | input | 1 | Clear the underflow flag |
| urun_o | output | 1 | Sticky underflow flag |

## Verification
The assertions take for granted that the FIFO is show-ahead: the head word is present on fifo_data_i whenever fifo_empty_i is low, and it changes only after a pop. They also assume mode_i and dscan_i do not change while a word is partly unpacked. The stimulus keeps to this. Its FIFO model refreshes the head word only after a clock edge, and depth and scan mode are changed only while en_i is low. Starvation, clear pulses and mid-word disables are applied at chosen slot positions, so that the expected pixel order and flag values can be worked out exactly.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MODE_4BPP  = 3'd1;
  localparam logic [MODE_W-1:0] MODE_8BPP  = 3'd2;
  localparam logic [MODE_W-1:0] MODE_16BPP = 3'd4;
  localparam logic [MODE_W-1:0] MODE_24BPP = 3'd6;

  typedef enum logic [1:0] {
    DEPTH_4B  = 2'd0,
    DEPTH_8B  = 2'd1,
    DEPTH_16B = 2'd2,
    DEPTH_24B = 2'd3
  } depth_e;

  localparam int NUM_DEPTHS = 4;

  function automatic int depth_bits(int d);
    case (d)
      0:       return 4;
      1:       return 8;
      2:       return 16;
      default: return 24;
    endcase
  endfunction
endpackage

// File: rtl/pxu_depth_dec.sv
module pxu_depth_dec
  import pxu_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int CNT_W  = 4
) (
  input  logic [MODE_W-1:0] mode_i,
  output depth_e            depth_o,
  output logic [CNT_W-1:0]  last_slot_o
);
  localparam int LAST_4  = WORD_W / 4 - 1;
  localparam int LAST_8  = WORD_W / 8 - 1;
  localparam int LAST_16 = WORD_W / 16 - 1;
  // 24-bit pixels: one per 32-bit half
  localparam int LAST_24 = WORD_W / 32 - 1;

  always_comb begin
    case (mode_i)
      MODE_4BPP:  depth_o = DEPTH_4B;
      MODE_16BPP: depth_o = DEPTH_16B;
      MODE_24BPP: depth_o = DEPTH_24B;
      default:    depth_o = DEPTH_8B;
    endcase
  end

  always_comb begin
    case (depth_o)
      DEPTH_4B:  last_slot_o = CNT_W'(LAST_4);
      DEPTH_16B: last_slot_o = CNT_W'(LAST_16);
      DEPTH_24B: last_slot_o = CNT_W'(LAST_24);
      default:   last_slot_o = CNT_W'(LAST_8);
    endcase
  end
endmodule

// File: rtl/pxu_fetch_ctrl.sv
module pxu_fetch_ctrl #(
  parameter int WORD_W = 64,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              pix_ce_i,
  input  logic              fifo_empty_i,
  input  logic [WORD_W-1:0] fifo_data_i,
  input  logic [CNT_W-1:0]  last_slot_i,
  input  logic              urun_clr_i,
  output logic              fifo_rd_o,
  output logic [WORD_W-1:0] word_o,
  output logic [CNT_W-1:0]  slot_o,
  output logic              step_o,
  output logic              urun_o
);
  logic              have_q;
  logic [CNT_W-1:0]  slot_q;
  logic [WORD_W-1:0] word_q;
  logic              urun_q;

  logic last_slot, step, take, prime, urun_set;

  always_comb begin
    // >= guards against a stale slot after a depth change
    last_slot = slot_q >= last_slot_i;
    step      = en_i & have_q & pix_ce_i;
    take      = step & last_slot;
    prime     = en_i & ~have_q;
    fifo_rd_o = (take | prime) & ~fifo_empty_i;
    urun_set  = fifo_empty_i & (take | (prime & pix_ce_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      slot_q <= '0;
    end else if (!en_i) begin
      have_q <= 1'b0;
      slot_q <= '0;
    end else begin
      if (fifo_rd_o) have_q <= 1'b1;
      if (step)      slot_q <= last_slot ? '0 : slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        word_q <= '0;
    else if (fifo_rd_o) word_q <= fifo_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) urun_q <= 1'b0;
    else         urun_q <= urun_set | (urun_q & ~urun_clr_i);
  end

  assign word_o = word_q;
  assign slot_o = slot_q;
  assign step_o = step;
  assign urun_o = urun_q;
endmodule

// File: rtl/pxu_slice_mux.sv
module pxu_slice_mux
  import pxu_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int PIX_W  = 24,
  parameter int CNT_W  = 4
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [CNT_W-1:0]  slot_i,
  input  depth_e            depth_i,
  input  logic              dscan_i,
  output logic [PIX_W-1:0]  pix_o
);
  localparam int HALF_W = WORD_W / 2;
  localparam int OFF_W  = $clog2(WORD_W) + CNT_W + 1;

  logic [OFF_W-1:0] bits;
  logic [OFF_W-1:0] off;
  logic [PIX_W-1:0] low;
  logic [PIX_W-1:0] cand [NUM_DEPTHS];

  always_comb begin
    bits = OFF_W'(depth_bits(int'(depth_i)));
    if (dscan_i)
      off = (slot_i[0] ? OFF_W'(HALF_W) : '0) + OFF_W'(slot_i >> 1) * bits;
    else
      off = OFF_W'(slot_i) * bits;
    low = PIX_W'(word_i >> off);
  end

  for (genvar g = 0; g < NUM_DEPTHS; g++) begin : g_depth
    localparam int DW = depth_bits(g);
    if (DW >= PIX_W) begin : g_full
      assign cand[g] = low;
    end else begin : g_ext
      assign cand[g] = {{(PIX_W - DW){1'b0}}, low[DW-1:0]};
    end
  end

  assign pix_o = cand[depth_i];
endmodule

// File: rtl/pixel_unpacker.sv
module pixel_unpacker
  import pxu_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int PIX_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              dscan_i,
  input  logic              pix_ce_i,
  input  logic [WORD_W-1:0] fifo_data_i,
  input  logic              fifo_empty_i,
  output logic              fifo_rd_o,
  output logic [PIX_W-1:0]  pix_o,
  output logic              pix_valid_o,
  input  logic              urun_clr_i,
  output logic              urun_o
);
  localparam int CNT_W = $clog2(WORD_W / 4);

  depth_e            depth;
  logic [CNT_W-1:0]  last_slot;
  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  slot;
  logic              step;
  logic [PIX_W-1:0]  slice;
  logic [PIX_W-1:0]  pix_q;
  logic              vld_q;

  pxu_depth_dec #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_dec (
    .mode_i      (mode_i),
    .depth_o     (depth),
    .last_slot_o (last_slot)
  );

  pxu_fetch_ctrl #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .pix_ce_i     (pix_ce_i),
    .fifo_empty_i (fifo_empty_i),
    .fifo_data_i  (fifo_data_i),
    .last_slot_i  (last_slot),
    .urun_clr_i   (urun_clr_i),
    .fifo_rd_o    (fifo_rd_o),
    .word_o       (word),
    .slot_o       (slot),
    .step_o       (step),
    .urun_o       (urun_o)
  );

  pxu_slice_mux #(.WORD_W(WORD_W), .PIX_W(PIX_W), .CNT_W(CNT_W)) u_mux (
    .word_i  (word),
    .slot_i  (slot),
    .depth_i (depth),
    .dscan_i (dscan_i),
    .pix_o   (slice)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= step;
      if (step) pix_q <= slice;
    end
  end

  assign pix_o       = pix_q;
  assign pix_valid_o = vld_q;
endmodule

// File: rtl/pxu_checker.sv
module pxu_checker
  import pxu_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [MODE_W-1:0] mode_i,
  input logic              pix_ce_i,
  input logic              fifo_empty_i,
  input logic              fifo_rd_o,
  input logic              urun_clr_i,
  input logic              urun_o,
  input logic              pix_valid_o,
  input logic [PIX_W-1:0]  pix_o
);
  // R5
  rd_not_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_o |-> !fifo_empty_i);

  // R9
  no_rd_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !fifo_rd_o);

  // R4
  valid_after_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> ($past(pix_ce_i) && $past(en_i)));

  // R3
  zext_4b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && $past(mode_i) == MODE_4BPP) |-> pix_o[PIX_W-1:4] == '0);

  // R3
  zext_8b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && $past(mode_i) == MODE_8BPP) |-> pix_o[PIX_W-1:8] == '0);

  // R3
  zext_16b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && $past(mode_i) == MODE_16BPP) |-> pix_o[PIX_W-1:16] == '0);

  // R7
  urun_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(urun_o) |-> $past(fifo_empty_i));

  // R8
  urun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (urun_o && !urun_clr_i) |=> urun_o);

  // R8
  urun_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (urun_clr_i && !fifo_empty_i) |=> !urun_o);
endmodule

bind pixel_unpacker pxu_checker #(.PIX_W(PIX_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .mode_i       (mode_i),
  .pix_ce_i     (pix_ce_i),
  .fifo_empty_i (fifo_empty_i),
  .fifo_rd_o    (fifo_rd_o),
  .urun_clr_i   (urun_clr_i),
  .urun_o       (urun_o),
  .pix_valid_o  (pix_valid_o),
  .pix_o        (pix_o)
);

// File: tb/pixel_unpacker_tb.sv
module pixel_unpacker_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [2:0]  mode = 3'd2;
  logic        dscan = 1'b0;
  logic        pix_ce = 1'b0;
  logic [63:0] fifo_data = '0;
  logic        fifo_empty = 1'b1;
  logic        urun_clr = 1'b0;
  logic        fifo_rd;
  logic [23:0] pix;
  logic        pix_valid;
  logic        urun;

  int n_chk = 0;
  int n_fail = 0;
  int rd_cnt = 0;
  bit done = 0;
  logic [63:0] seed = 64'h0123_4567_89AB_CDEF;

  logic [63:0] fifo_q[$];
  logic [23:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  pixel_unpacker u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .en_i         (en),
    .mode_i       (mode),
    .dscan_i      (dscan),
    .pix_ce_i     (pix_ce),
    .fifo_data_i  (fifo_data),
    .fifo_empty_i (fifo_empty),
    .fifo_rd_o    (fifo_rd),
    .pix_o        (pix),
    .pix_valid_o  (pix_valid),
    .urun_clr_i   (urun_clr),
    .urun_o       (urun)
  );

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic int bpp(logic [2:0] m);
    case (m)
      3'd1:    return 4;
      3'd4:    return 16;
      3'd6:    return 24;
      default: return 8;
    endcase
  endfunction

  function automatic int slots(logic [2:0] m);
    return (bpp(m) == 24) ? 2 : 64 / bpp(m);
  endfunction

  function automatic logic [23:0] exp_pix(logic [63:0] w, logic [2:0] m, bit ds, int s);
    int b;
    int off;
    logic [63:0] t;
    b = bpp(m);
    off = ds ? ((s % 2) * 32 + (s / 2) * b) : s * b;
    t = w >> off;
    return 24'(t & ((64'd1 << b) - 64'd1));
  endfunction

  function automatic logic [63:0] next_word();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return seed;
  endfunction

  task automatic fifo_refresh();
    fifo_empty = (fifo_q.size() == 0);
    fifo_data  = fifo_empty ? '0 : fifo_q[0];
  endtask

  task automatic push_word(logic [63:0] w);
    fifo_q.push_back(w);
    fifo_refresh();
  endtask

  task automatic expect_pix(logic [23:0] v, string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic expect_word(logic [63:0] w, logic [2:0] m, bit ds, string t);
    for (int s = 0; s < slots(m); s++) expect_pix(exp_pix(w, m, ds, s), t);
  endtask

  // FIFO model: pop after the edge that saw the read strobe
  always @(posedge clk) begin
    bit rd_s;
    rd_s = rst_n && fifo_rd;
    #1;
    if (rd_s && fifo_q.size() > 0) begin
      void'(fifo_q.pop_front());
      rd_cnt++;
    end
    fifo_refresh();
  end

  // Monitor
  always @(negedge clk) begin
    if (rst_n && pix_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4", "unexpected pixel", {40'd0, pix}, 64'd0);
      end else begin
        logic [23:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(pix == e, t, "pixel value", {40'd0, pix}, {40'd0, e});
      end
    end
  end

  task automatic pulses(int n, bit gappy);
    for (int i = 0; i < n; i++) begin
      pix_ce = 1'b1;
      @(negedge clk);
      if (gappy) begin
        pix_ce = 1'b0;
        @(negedge clk);
        if (i % 3 == 0) @(negedge clk);
      end
    end
    pix_ce = 1'b0;
  endtask

  task automatic run_frame(logic [2:0] m, bit ds, int nw, bit gappy, string t);
    @(negedge clk);
    en = 1'b0; mode = m; dscan = ds; pix_ce = 1'b0;
    @(negedge clk);
    for (int w = 0; w < nw; w++) begin
      logic [63:0] d;
      d = next_word();
      push_word(d);
      expect_word(d, m, ds, t);
    end
    push_word(next_word());
    rd_cnt = 0;
    en = 1'b1;
    @(negedge clk);
    pulses(nw * slots(m), gappy);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, t, "all pixels emitted", 64'(exp_q.size()), 64'd0);
    chk(rd_cnt == nw + 1, "R5", "word reads per frame", 64'(rd_cnt), 64'(nw + 1));
    chk(urun == 1'b0, "R7", "no underflow when fed", {63'd0, urun}, 64'd0);
    en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [63:0] wa, wb, ws;
    repeat (3) @(negedge clk);
    // R1
    chk(pix_valid == 1'b0 && fifo_rd == 1'b0 && urun == 1'b0, "R1", "outputs in reset",
        {61'd0, pix_valid, fifo_rd, urun}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(pix_valid == 1'b0 && fifo_rd == 1'b0 && urun == 1'b0, "R1", "outputs idle after reset",
        {61'd0, pix_valid, fifo_rd, urun}, 64'd0);

    // R3: known 4 bpp word, slot s equals s
    mode = 3'd1; dscan = 1'b0;
    push_word(64'hFEDC_BA98_7654_3210);
    push_word(64'd0);
    for (int s = 0; s < 16; s++) expect_pix(24'(s), "R3");
    rd_cnt = 0;
    en = 1'b1;
    @(negedge clk);
    pulses(16, 1'b0);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R3", "lsb-first nibbles", 64'(exp_q.size()), 64'd0);
    chk(rd_cnt == 2, "R5", "read at last slot", 64'(rd_cnt), 64'd2);
    en = 1'b0;
    @(negedge clk);

    // R2 depths, single scan
    run_frame(3'd1, 1'b0, 2, 1'b0, "R2");
    run_frame(3'd2, 1'b0, 3, 1'b0, "R2");
    run_frame(3'd4, 1'b0, 3, 1'b0, "R2");
    run_frame(3'd6, 1'b0, 4, 1'b0, "R2");
    run_frame(3'd7, 1'b0, 2, 1'b0, "R2");
    run_frame(3'd0, 1'b0, 1, 1'b0, "R2");
    // R4 gappy pixel enable
    run_frame(3'd2, 1'b0, 2, 1'b1, "R4");
    run_frame(3'd6, 1'b0, 3, 1'b1, "R4");
    // R6 dual scan
    run_frame(3'd2, 1'b1, 2, 1'b0, "R6");
    run_frame(3'd1, 1'b1, 2, 1'b1, "R6");
    run_frame(3'd4, 1'b1, 2, 1'b0, "R6");
    run_frame(3'd6, 1'b1, 3, 1'b0, "R6");

    // R9: disable mid-word
    mode = 3'd2; dscan = 1'b0;
    wa = next_word(); wb = next_word();
    push_word(wa); push_word(wb); push_word(next_word());
    for (int s = 0; s < 3; s++) expect_pix(exp_pix(wa, 3'd2, 1'b0, s), "R9");
    rd_cnt = 0;
    en = 1'b1;
    repeat (3) @(negedge clk);
    chk(pix_valid == 1'b0, "R4", "no pixel without enable pulse", {63'd0, pix_valid}, 64'd0);
    chk(rd_cnt == 1, "R5", "single priming read", 64'(rd_cnt), 64'd1);
    pulses(3, 1'b0);
    en = 1'b0;
    @(negedge clk);
    pix_ce = 1'b1;
    repeat (3) @(negedge clk);
    pix_ce = 1'b0;
    chk(pix_valid == 1'b0, "R9", "no pixel while disabled", {63'd0, pix_valid}, 64'd0);
    chk(rd_cnt == 1 && fifo_q.size() == 2, "R9", "no read while disabled",
        64'(rd_cnt), 64'd1);
    expect_word(wb, 3'd2, 1'b0, "R9");
    en = 1'b1;
    @(negedge clk);
    pulses(8, 1'b0);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "restart at slot 0 of new word", 64'(exp_q.size()), 64'd0);
    chk(rd_cnt == 3, "R9", "reads after re-enable", 64'(rd_cnt), 64'd3);
    en = 1'b0;
    @(negedge clk);

    // R7 / R8: starvation at 24 bpp
    mode = 3'd6; dscan = 1'b0;
    urun_clr = 1'b1;
    @(negedge clk);
    urun_clr = 1'b0;
    @(negedge clk);
    chk(urun == 1'b0, "R8", "flag clear before starve", {63'd0, urun}, 64'd0);
    ws = next_word();
    push_word(ws);
    for (int r = 0; r < 2; r++) begin
      expect_pix(exp_pix(ws, 3'd6, 1'b0, 0), "R7");
      expect_pix(exp_pix(ws, 3'd6, 1'b0, 1), "R7");
    end
    rd_cnt = 0;
    en = 1'b1;
    @(negedge clk);
    pulses(4, 1'b0);
    @(negedge clk);
    chk(urun == 1'b1, "R7", "underflow set", {63'd0, urun}, 64'd1);
    chk(rd_cnt == 1, "R7", "no read while starved", 64'(rd_cnt), 64'd1);
    chk(exp_q.size() == 0, "R7", "word replayed", 64'(exp_q.size()), 64'd0);
    repeat (3) @(negedge clk);
    chk(urun == 1'b1, "R8", "flag sticky", {63'd0, urun}, 64'd1);
    urun_clr = 1'b1;
    @(negedge clk);
    urun_clr = 1'b0;
    @(negedge clk);
    chk(urun == 1'b0, "R8", "flag cleared", {63'd0, urun}, 64'd0);
    expect_pix(exp_pix(ws, 3'd6, 1'b0, 0), "R8");
    expect_pix(exp_pix(ws, 3'd6, 1'b0, 1), "R8");
    pix_ce = 1'b1;
    @(negedge clk);
    urun_clr = 1'b1;
    @(negedge clk);
    pix_ce = 1'b0;
    urun_clr = 1'b0;
    @(negedge clk);
    chk(urun == 1'b1, "R8", "set wins over clear", {63'd0, urun}, 64'd1);
    chk(exp_q.size() == 0, "R8", "pixels during clear", 64'(exp_q.size()), 64'd0);
    en = 1'b0;
    repeat (2) @(negedge clk);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule